// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two 8-bit buses, called A and B, and keeps one edge-clocked holding register for each direction of transfer. The word travelling toward bus B is either the live value seen on bus A or the copy of bus A last captured by its own clock. The word travelling toward bus A is chosen the same way from bus B and its own register. An active-low enable and a direction input decide which single bus, if any, the block drives.

Each tri-state bus is modelled as three vectors: an input carrying the value seen on the wires, an output carrying the value the block would drive, and an output-enable. This keeps the block synthesizable and lets every pin be checked. The registers keep loading while both outputs are off, so the block can be used as a transceiver or as a pair of working registers.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On each rising edge of `clkAtoB`, the value on `busAIn` is stored in the A-side register.
- R2: On each rising edge of `clkBtoA`, the value on `busBIn` is stored in the B-side register.
- R3: Each register changes only on a rising edge of its own clock. An edge of the other clock leaves it unchanged.
- R4: When bus B is driven, `busBOut` equals `busAIn` if `selStoredToB` is 0 and equals the A-side register if `selStoredToB` is 1.
- R5: When bus A is driven, `busAOut` equals `busBIn` if `selStoredToA` is 0 and equals the B-side register if `selStoredToA` is 1.
- R6: With `enN` = 0 and `dirToB` = 1, `busBOe` is all ones and `busAOe` is all zeros. With `enN` = 0 and `dirToB` = 0, `busAOe` is all ones and `busBOe` is all zeros.
- R7: With `enN` = 1, both output-enables are all zeros. The output value of any bus that is not driven is all zeros.
- R8: Both registers keep capturing on their clock edges while `enN` = 1.
- R9: Driving `rstN` low clears both registers to zero at once, without waiting for a clock edge.
- R10: The output multiplexers are combinational. A change on a select, enable, direction or live bus input shows on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of both registers |
| clkAtoB | input | 1 | Capture clock of the A-side register |
| clkBtoA | input | 1 | Capture clock of the B-side register |
| enN | input | 1 | Active-low output enable |
| dirToB | input | 1 | 1: drive bus B, 0: drive bus A (when enabled) |
| selStoredToB | input | 1 | 1: send the stored A word toward B, 0: send live A |
| selStoredToA | input | 1 | 1: send the stored B word toward A, 0: send live B |
| busAIn | input | 8 | Value present on bus A |
| busAOut | output | 8 | Value driven onto bus A |
| busAOe | output | 8 | Drive enable of bus A, per bit |
| busBIn | input | 8 | Value present on bus B |
| busBOut | output | 8 | Value driven onto bus B |
| busBOe | output | 8 | Drive enable of bus B, per bit |

## Verification
A register that is not loaded, is loaded by the wrong clock, or keeps a stale word shows up on the driven bus as soon as stored mode is selected. No further edge is needed, because the output path is combinational. The bench therefore reads each register back through stored mode right after every capture, and also after each edge of the other clock. A wrong decode of enable or direction shows at once on the enable vectors. The bench sweeps all sixteen control combinations against computed expected values.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic storedToA;
    logic storedToB;
  } xcvrCtrlT;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic     enN,
  input  logic     dirToB,
  input  logic     selStoredToB,
  input  logic     selStoredToA,
  output xcvrCtrlT ctrl
);
  always_comb begin
    ctrl.driveB    = !enN && dirToB;
    ctrl.driveA    = !enN && !dirToB;
    ctrl.storedToA = selStoredToA;
    ctrl.storedToB = selStoredToB;
  end

  // R6: never both buses driven
  always_comb begin
    p_one_bus_r6: assert (!(ctrl.driveA && ctrl.driveB))
      else $error("both buses driven");
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             clk,
  input  logic [WIDTH-1:0] liveIn,
  input  logic             useStored,
  input  logic             drive,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] oe
);
  logic [WIDTH-1:0] stored;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stored <= '0;
    else       stored <= liveIn;
  end

  always_comb begin
    if (drive) dataOut = useStored ? stored : liveIn;
    else       dataOut = '0;
    oe = {WIDTH{drive}};
  end

  // R1 / R2: register holds the word present at the previous own edge
  p_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (stored == $past(liveIn)))
    else $error("register lost captured word");
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  xcvrCtrlT         ctrl,
  input  logic [WIDTH-1:0] busAIn,
  input  logic [WIDTH-1:0] busBIn,
  output logic [WIDTH-1:0] busAOut,
  output logic [WIDTH-1:0] busAOe,
  output logic [WIDTH-1:0] busBOut,
  output logic [WIDTH-1:0] busBOe
);
  localparam int LANES = 2;

  logic             laneClk    [LANES];
  logic [WIDTH-1:0] laneLive   [LANES];
  logic             laneStored [LANES];
  logic             laneDrive  [LANES];
  logic [WIDTH-1:0] laneOut    [LANES];
  logic [WIDTH-1:0] laneOe     [LANES];

  // lane 0 carries A toward B, lane 1 carries B toward A
  always_comb begin
    laneClk[0]    = clkAtoB;
    laneLive[0]   = busAIn;
    laneStored[0] = ctrl.storedToB;
    laneDrive[0]  = ctrl.driveB;
    laneClk[1]    = clkBtoA;
    laneLive[1]   = busBIn;
    laneStored[1] = ctrl.storedToA;
    laneDrive[1]  = ctrl.driveA;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    xcvr_lane #(.WIDTH(WIDTH)) uLane (
      .rstN     (rstN),
      .clk      (laneClk[g]),
      .liveIn   (laneLive[g]),
      .useStored(laneStored[g]),
      .drive    (laneDrive[g]),
      .dataOut  (laneOut[g]),
      .oe       (laneOe[g])
    );
  end

  assign busBOut = laneOut[0];
  assign busBOe  = laneOe[0];
  assign busAOut = laneOut[1];
  assign busAOe  = laneOe[1];
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             enN,
  input  logic             dirToB,
  input  logic             selStoredToB,
  input  logic             selStoredToA,
  input  logic [WIDTH-1:0] busAIn,
  output logic [WIDTH-1:0] busAOut,
  output logic [WIDTH-1:0] busAOe,
  input  logic [WIDTH-1:0] busBIn,
  output logic [WIDTH-1:0] busBOut,
  output logic [WIDTH-1:0] busBOe
);
  xcvrCtrlT ctrl;

  xcvr_ctrl uCtrl (
    .enN         (enN),
    .dirToB      (dirToB),
    .selStoredToB(selStoredToB),
    .selStoredToA(selStoredToA),
    .ctrl        (ctrl)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) uDp (
    .rstN   (rstN),
    .clkAtoB(clkAtoB),
    .clkBtoA(clkBtoA),
    .ctrl   (ctrl),
    .busAIn (busAIn),
    .busBIn (busBIn),
    .busAOut(busAOut),
    .busAOe (busAOe),
    .busBOut(busBOut),
    .busBOe (busBOe)
  );

  // R7: disabled block drives nothing
  always_comb begin
    p_all_off_r7: assert (!enN || (busAOe == '0 && busBOe == '0))
      else $error("output enabled while enN high");
    p_idle_zero_r7: assert (((busAOe != '0) || (busAOut == '0)) &&
                            ((busBOe != '0) || (busBOut == '0)))
      else $error("undriven bus output not zero");
  end
endmodule

// File: tb/sim_reg_bus_xcvr.sv
module sim_reg_bus_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0;
  logic rstN, clkAtoB, clkBtoA, enN, dirToB, selStoredToB, selStoredToA;
  logic [W-1:0] busAIn, busBIn, busAOut, busAOe, busBOut, busBOe;
  logic [W-1:0] expRegA, expRegB;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) u0 (
    .rstN(rstN), .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .enN(enN),
    .dirToB(dirToB), .selStoredToB(selStoredToB), .selStoredToA(selStoredToA),
    .busAIn(busAIn), .busAOut(busAOut), .busAOe(busAOe),
    .busBIn(busBIn), .busBOut(busBOut), .busBOe(busBOe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseA();
    @(negedge clk); clkAtoB = 1; expRegA = busAIn;
    @(negedge clk); clkAtoB = 0;
  endtask

  task automatic pulseB();
    @(negedge clk); clkBtoA = 1; expRegB = busBIn;
    @(negedge clk); clkBtoA = 0;
  endtask

  // read both registers back through stored mode, then restore controls
  task automatic readBack(input string req);
    logic e, d, sa, sb;
    e = enN; d = dirToB; sa = selStoredToA; sb = selStoredToB;
    enN = 0; selStoredToA = 1; selStoredToB = 1;
    dirToB = 1; #1 check(req, busBOut, expRegA);
    dirToB = 0; #1 check(req, busAOut, expRegB);
    enN = e; dirToB = d; selStoredToA = sa; selStoredToB = sb; #1;
  endtask

  task automatic checkAll();
    logic [W-1:0] eAOe, eBOe, eAOut, eBOut;
    eBOe = (!enN && dirToB) ? '1 : '0;
    eAOe = (!enN && !dirToB) ? '1 : '0;
    eBOut = (eBOe != 0) ? (selStoredToB ? expRegA : busAIn) : '0;
    eAOut = (eAOe != 0) ? (selStoredToA ? expRegB : busBIn) : '0;
    check(enN ? "R7 oeA" : "R6 oeA", busAOe, eAOe);
    check(enN ? "R7 oeB" : "R6 oeB", busBOe, eBOe);
    check(selStoredToB ? "R4 stored" : "R4 live", busBOut, eBOut);
    check(selStoredToA ? "R5 stored" : "R5 live", busAOut, eAOut);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        done = 1;
      end
    end
  end

  initial begin
    rstN = 0; clkAtoB = 0; clkBtoA = 0; enN = 1; dirToB = 0;
    selStoredToA = 0; selStoredToB = 0; busAIn = 8'h3C; busBIn = 8'hC3;
    expRegA = 0; expRegB = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    readBack("R9 reset zero");

    // R1 R2 R3: captures and independence of the two clocks
    for (int i = 0; i < 16; i++) begin
      busAIn = W'(i * 37 + 5); busBIn = W'(i * 91 + 200);
      if (i % 2 == 0) begin
        pulseA(); readBack("R1 capture / R3 B unchanged");
      end else begin
        pulseB(); readBack("R2 capture / R3 A unchanged");
      end
    end

    // R4 R5 R6 R7 R10: sweep all controls with several data patterns
    for (int p = 0; p < 6; p++) begin
      busAIn = W'(p * 53 + 1); pulseA();
      busBIn = W'(p * 29 + 128); pulseB();
      busAIn = ~busAIn ^ W'(p); busBIn = busBIn + 8'h11;
      for (int c = 0; c < 16; c++) begin
        {enN, dirToB, selStoredToB, selStoredToA} = 4'(c);
        #1 checkAll();
        busAIn = busAIn + 8'h05; busBIn = busBIn - 8'h03;
        #1 checkAll();
      end
    end

    // R10: select change reflected with no clock edge
    enN = 0; dirToB = 1; busAIn = 8'hA5; pulseA(); busAIn = 8'h5A;
    selStoredToB = 0; #1 check("R10 live", busBOut, 8'h5A);
    selStoredToB = 1; #1 check("R10 stored", busBOut, 8'hA5);

    // R8: capture while outputs are disabled
    enN = 1;
    busAIn = 8'hFF; busBIn = 8'h00; pulseA(); pulseB();
    #1 check("R8 oeA off", busAOe, 8'h00);
    check("R8 oeB off", busBOe, 8'h00);
    readBack("R8 capture while disabled");
    busAIn = 8'h81; busBIn = 8'h7E; pulseB(); pulseA();
    readBack("R8 capture while disabled");

    // R9: asynchronous clear away from any clock edge
    #2 rstN = 0; expRegA = 0; expRegB = 0;
    #1 rstN = 1;
    readBack("R9 async clear");

    done = 1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule